// File: doc/BRIEF.md
# Coherence message event classifier

This block sits in front of a shared-cache line controller and turns each incoming coherence message into exactly one protocol event. The event does not follow from the type code alone: it also depends on the directory state the lookup stage presents with the message (line valid bit, sharer vector, free-way flag, victim dirty bit and the outstanding-ack count).

Upgrade and writeback requests are reinterpreted according to whether the sender is still a sharer. A request that would need a fill while the set has no free way is turned into a replacement event aimed at the victim line. The decision is registered and held under a valid/acknowledge handshake. The block takes no new message until the line controller has consumed the held event. A type code with no meaning for its class raises a one-cycle error pulse instead of an event.

Message classes on `msg_class_i`: 0 = L1 request, 1 = L1 response, 2 = memory response, 3 = unblock.
- L1 request types: 0 read, 1 instruction fetch, 2 write, 3 upgrade, 4 writeback.
- L1 response types: 0 data, 1 ack.
- Memory response types: 0 data, 1 ack, 2 invalidate.
- Unblock types: 0 plain, 1 exclusive.

Event codes on `evt_code_o`: 1 read, 2 ifetch, 3 write, 4 upgrade, 5 writeback, 6 stale writeback, 7 dirty replacement, 8 clean replacement, 9 dirty L1 data, 10 clean L1 data, 11 intermediate ack, 12 final ack, 13 memory data, 14 memory ack, 15 memory invalidate, 16 unblock, 17 exclusive unblock.

Top module: `coh_evt_classifier`

## Requirements
- R1: After reset `evt_valid_o` and `evt_err_o` are 0 and `msg_ready_o` is 1.
- R2: Within an L1 request (class 0), a read (type 0) yields event 1 and an instruction fetch (type 1) yields event 2. A write (type 2) yields event 3.
- R3: An upgrade (class 0, type 3) yields event 4 only when the line is valid and bit `sender_id_i` of `sharers_i` is set. Otherwise it yields event 3 (write).
- R4: A writeback (class 0, type 4) yields event 5 when the line is valid and the sender is a sharer. Otherwise it yields event 6 (stale writeback).
- R5: For a known L1 request type with `line_valid_i`=0 and `way_free_i`=0, the event is 7 if `victim_dirty_i`=1 and 8 otherwise, and `evt_victim_o`=1. In every other case `evt_victim_o`=0, and responses from any class are never replaced.
- R6: L1 data (class 1, type 0) yields event 9 when `msg_dirty_i`=1 and event 10 when it is 0.
- R7: An L1 ack (class 1, type 1) yields event 12 when `pend_acks_i` minus `msg_ack_cnt_i` (modulo 2^ACK_W) is zero. Otherwise it yields event 11.
- R8: A memory response (class 2) of type 0, 1 or 2 yields event 13, 14 or 15 respectively.
- R9: An unblock (class 3) of type 0 yields event 16 and one of type 1 yields event 17.
- R10: An unknown type code for the message's class sets `evt_err_o` for one cycle after acceptance and produces no event, even when the set is full. `msg_ready_o` stays 1.
- R11: A message is accepted on a clock edge where `msg_valid_i` and `msg_ready_o` are both 1. The event appears with `evt_valid_o` one cycle later. It is then held stable, with `msg_ready_o`=0, until a cycle with `evt_ack_i`=1, after which `evt_valid_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message present |
| msg_ready_o | output | 1 | Classifier can take a message |
| msg_class_i | input | 2 | Message class |
| msg_type_i | input | 3 | Type code within the class |
| sender_id_i | input | ID_W | Sending L1 index |
| msg_dirty_i | input | 1 | Data carried is dirty |
| msg_ack_cnt_i | input | ACK_W | Ack count carried by an L1 ack |
| line_valid_i | input | 1 | Addressed line is present |
| sharers_i | input | N_L1 | Sharer vector of the line |
| way_free_i | input | 1 | A way is free in the set |
| victim_dirty_i | input | 1 | Victim line is dirty |
| pend_acks_i | input | ACK_W | Acks still outstanding for the line |
| evt_valid_o | output | 1 | Event held for the controller |
| evt_ack_i | input | 1 | Controller consumed the event |
| evt_code_o | output | 5 | Event code |
| evt_victim_o | output | 1 | Event refers to the victim address |
| evt_err_o | output | 1 | Unknown type code seen |

## Verification
Sharer reinterpretation and replacement substitution can apply to the same message. An upgrade from a non-sharer that targets an absent line in a full set is sent to provoke this, and it must come out as a replacement with the victim selector set, not as a write. An unknown type presented against a full set is sent the same way, and must raise the error pulse with no replacement. The scoreboard monitor holds every event for an extra cycle before acknowledging it, so that it can judge whether the event stays stable and whether the block refuses input while it is held.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;
  typedef enum logic [1:0] {
    CL_L1_REQ = 2'd0,
    CL_L1_RSP = 2'd1,
    CL_MEM    = 2'd2,
    CL_UNBLK  = 2'd3
  } msg_class_e;

  localparam logic [2:0] REQ_READ  = 3'd0;
  localparam logic [2:0] REQ_IFET  = 3'd1;
  localparam logic [2:0] REQ_WRITE = 3'd2;
  localparam logic [2:0] REQ_UPG   = 3'd3;
  localparam logic [2:0] REQ_WB    = 3'd4;
  localparam logic [2:0] RSP_DATA  = 3'd0;
  localparam logic [2:0] RSP_ACK   = 3'd1;
  localparam logic [2:0] MEM_DATA  = 3'd0;
  localparam logic [2:0] MEM_ACK   = 3'd1;
  localparam logic [2:0] MEM_INV   = 3'd2;
  localparam logic [2:0] UB_PLAIN  = 3'd0;
  localparam logic [2:0] UB_EXCL   = 3'd1;

  typedef enum logic [4:0] {
    EV_NONE     = 5'd0,
    EV_READ     = 5'd1,
    EV_IFET     = 5'd2,
    EV_WRITE    = 5'd3,
    EV_UPG      = 5'd4,
    EV_WB       = 5'd5,
    EV_WB_STALE = 5'd6,
    EV_REPL_D   = 5'd7,
    EV_REPL_C   = 5'd8,
    EV_DATA_D   = 5'd9,
    EV_DATA_C   = 5'd10,
    EV_ACK_MID  = 5'd11,
    EV_ACK_LAST = 5'd12,
    EV_MDATA    = 5'd13,
    EV_MACK     = 5'd14,
    EV_MINV     = 5'd15,
    EV_UNBLK    = 5'd16,
    EV_UNBLK_X  = 5'd17
  } evt_e;
endpackage

// File: rtl/coh_sharer_hit.sv
module coh_sharer_hit #(
  parameter int N_L1 = 8,
  localparam int ID_W = (N_L1 > 1) ? $clog2(N_L1) : 1
) (
  input  logic [N_L1-1:0] sharers_i,
  input  logic [ID_W-1:0] id_i,
  output logic            hit_o
);
  logic [N_L1-1:0] match;
  for (genvar g = 0; g < N_L1; g++) begin : g_cmp
    assign match[g] = sharers_i[g] && (id_i == ID_W'(g));
  end
  assign hit_o = |match;
endmodule

// File: rtl/coh_evt_decode.sv
module coh_evt_decode
  import coh_evt_pkg::*;
#(
  parameter int ACK_W = 4
) (
  input  logic [1:0]       cls_i,
  input  logic [2:0]       typ_i,
  input  logic             dirty_i,
  input  logic [ACK_W-1:0] ack_cnt_i,
  input  logic             line_valid_i,
  input  logic             sharer_i,
  input  logic             way_free_i,
  input  logic             victim_dirty_i,
  input  logic [ACK_W-1:0] pend_acks_i,
  output evt_e             evt_o,
  output logic             victim_o,
  output logic             err_o
);
  logic [ACK_W-1:0] ack_left;
  logic             owned;
  assign ack_left = pend_acks_i - ack_cnt_i;
  assign owned    = line_valid_i && sharer_i;

  always_comb begin
    evt_o    = EV_NONE;
    err_o    = 1'b0;
    victim_o = 1'b0;
    case (msg_class_e'(cls_i))
      CL_L1_REQ: begin
        case (typ_i)
          REQ_READ:  evt_o = EV_READ;
          REQ_IFET:  evt_o = EV_IFET;
          REQ_WRITE: evt_o = EV_WRITE;
          REQ_UPG:   evt_o = owned ? EV_UPG : EV_WRITE;
          REQ_WB:    evt_o = owned ? EV_WB : EV_WB_STALE;
          default:   err_o = 1'b1;
        endcase
        // full set: make room before serving the request
        if (!err_o && !line_valid_i && !way_free_i) begin
          victim_o = 1'b1;
          evt_o    = victim_dirty_i ? EV_REPL_D : EV_REPL_C;
        end
      end
      CL_L1_RSP: begin
        case (typ_i)
          RSP_DATA: evt_o = dirty_i ? EV_DATA_D : EV_DATA_C;
          RSP_ACK:  evt_o = (ack_left == '0) ? EV_ACK_LAST : EV_ACK_MID;
          default:  err_o = 1'b1;
        endcase
      end
      CL_MEM: begin
        case (typ_i)
          MEM_DATA: evt_o = EV_MDATA;
          MEM_ACK:  evt_o = EV_MACK;
          MEM_INV:  evt_o = EV_MINV;
          default:  err_o = 1'b1;
        endcase
      end
      default: begin
        case (typ_i)
          UB_PLAIN: evt_o = EV_UNBLK;
          UB_EXCL:  evt_o = EV_UNBLK_X;
          default:  err_o = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/coh_evt_stage.sv
module coh_evt_stage
  import coh_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  evt_e evt_i,
  input  logic victim_i,
  input  logic err_i,
  input  logic ack_i,
  output logic valid_o,
  output evt_e evt_o,
  output logic victim_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      evt_o    <= EV_NONE;
      victim_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= take_i && err_i;
      if (take_i && !err_i) begin
        valid_o  <= 1'b1;
        evt_o    <= evt_i;
        victim_o <= victim_i;
      end else if (ack_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(evt_o) && $stable(victim_o));
  p_ack_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ack_i && !take_i |=> !valid_o);
  p_err_noevt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && err_i && !valid_o |=> err_o && !valid_o);
endmodule

// File: rtl/coh_evt_classifier.sv
module coh_evt_classifier
  import coh_evt_pkg::*;
#(
  parameter int N_L1  = 8,
  parameter int ACK_W = 4,
  localparam int ID_W = (N_L1 > 1) ? $clog2(N_L1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  output logic             msg_ready_o,
  input  logic [1:0]       msg_class_i,
  input  logic [2:0]       msg_type_i,
  input  logic [ID_W-1:0]  sender_id_i,
  input  logic             msg_dirty_i,
  input  logic [ACK_W-1:0] msg_ack_cnt_i,
  input  logic             line_valid_i,
  input  logic [N_L1-1:0]  sharers_i,
  input  logic             way_free_i,
  input  logic             victim_dirty_i,
  input  logic [ACK_W-1:0] pend_acks_i,
  output logic             evt_valid_o,
  input  logic             evt_ack_i,
  output logic [4:0]       evt_code_o,
  output logic             evt_victim_o,
  output logic             evt_err_o
);
  logic sharer, take, d_victim, d_err, q_victim, q_err, q_valid;
  evt_e d_evt, q_evt;

  assign msg_ready_o = !q_valid;
  assign take        = msg_valid_i && msg_ready_o;

  coh_sharer_hit #(.N_L1(N_L1)) u_hit (
    .sharers_i(sharers_i), .id_i(sender_id_i), .hit_o(sharer));

  coh_evt_decode #(.ACK_W(ACK_W)) u_dec (
    .cls_i(msg_class_i), .typ_i(msg_type_i), .dirty_i(msg_dirty_i),
    .ack_cnt_i(msg_ack_cnt_i), .line_valid_i(line_valid_i), .sharer_i(sharer),
    .way_free_i(way_free_i), .victim_dirty_i(victim_dirty_i),
    .pend_acks_i(pend_acks_i), .evt_o(d_evt), .victim_o(d_victim), .err_o(d_err));

  coh_evt_stage u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .evt_i(d_evt),
    .victim_i(d_victim), .err_i(d_err), .ack_i(evt_ack_i), .valid_o(q_valid),
    .evt_o(q_evt), .victim_o(q_victim), .err_o(q_err));

  assign evt_valid_o  = q_valid;
  assign evt_code_o   = q_evt;
  assign evt_victim_o = q_victim;
  assign evt_err_o    = q_err;

  p_repl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && msg_class_i == CL_L1_REQ && msg_type_i <= REQ_WB &&
    !line_valid_i && !way_free_i |=> evt_valid_o && evt_victim_o &&
    (evt_code_o == EV_REPL_D || evt_code_o == EV_REPL_C));
  p_upg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && msg_class_i == CL_L1_REQ && msg_type_i == REQ_UPG &&
    line_valid_i && !sharers_i[sender_id_i] |=> evt_code_o == EV_WRITE);
  p_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && msg_class_i == CL_L1_RSP && msg_type_i == RSP_ACK &&
    pend_acks_i == msg_ack_cnt_i |=> evt_code_o == EV_ACK_LAST);
  p_rsp_novic_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && msg_class_i != CL_L1_REQ |=> !evt_victim_o);
endmodule

// File: tb/tb_coh_evt_classifier.sv
`timescale 1ns/1ps
module tb_coh_evt_classifier;
  localparam int N_L1 = 8, ACK_W = 4, ID_W = 3;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_ready;
  logic [1:0] cls = 0;
  logic [2:0] typ = 0;
  logic [ID_W-1:0] sid = 0;
  logic dirty = 0, lv = 0, wf = 0, vd = 0, ack = 0;
  logic [ACK_W-1:0] acnt = 0, pend = 0;
  logic [N_L1-1:0] sh = 0;
  logic evt_valid, evt_vic, evt_err;
  logic [4:0] evt_code;

  typedef struct {
    int    code;
    bit    vic;
    bit    err;
    string req;
  } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  coh_evt_classifier #(.N_L1(N_L1), .ACK_W(ACK_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_ready_o(msg_ready),
    .msg_class_i(cls), .msg_type_i(typ), .sender_id_i(sid), .msg_dirty_i(dirty),
    .msg_ack_cnt_i(acnt), .line_valid_i(lv), .sharers_i(sh), .way_free_i(wf),
    .victim_dirty_i(vd), .pend_acks_i(pend), .evt_valid_o(evt_valid),
    .evt_ack_i(ack), .evt_code_o(evt_code), .evt_victim_o(evt_vic),
    .evt_err_o(evt_err));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [2:0] t, input int id,
                      input bit d, input int cnt, input bit l, input bit w,
                      input bit v, input int p, input int ecode, input bit evic,
                      input bit eerr, input string req);
    exp_t e;
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    cls = c; typ = t; sid = ID_W'(id); dirty = d; acnt = ACK_W'(cnt);
    lv = l; wf = w; vd = v; pend = ACK_W'(p); msg_valid = 1;
    e.code = ecode; e.vic = evic; e.err = eerr; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    #1 msg_valid = 0;
  endtask

  // monitor: pop, compare, hold one extra cycle, then acknowledge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (evt_valid || evt_err)) begin
        if (sb.size() == 0) begin
          chk(0, "spurious", int'(evt_code), 0);
        end else begin
          e = sb.pop_front();
          if (e.err) begin
            chk(evt_err && !evt_valid, e.req, int'(evt_err), 1);
          end else begin
            chk(evt_valid && !evt_err && int'(evt_code) == e.code, e.req,
                int'(evt_code), e.code);
            chk(evt_vic == e.vic, {e.req, " victim"}, int'(evt_vic), int'(e.vic));
          end
        end
        if (evt_valid) begin
          @(negedge clk);
          chk(evt_valid && !msg_ready && int'(evt_code) == e.code,
              "R11 hold", int'(evt_code), e.code);
          ack = 1;
          @(negedge clk);
          ack = 0;
          chk(!evt_valid && msg_ready, "R11 release", int'(evt_valid), 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    sh = 8'b0000_0110;  // sharers: L1 1 and L1 2
    repeat (3) @(negedge clk);
    chk(!evt_valid && !evt_err && msg_ready, "R1 reset", int'(evt_valid), 0);
    rst_n = 1;
    // R2
    send(0, 0, 1, 0, 0, 1, 1, 0, 0, 1, 0, 0, "R2 read");
    send(0, 1, 3, 0, 0, 1, 1, 0, 0, 2, 0, 0, "R2 ifetch");
    send(0, 2, 3, 0, 0, 1, 0, 0, 0, 3, 0, 0, "R2 write");
    // R3
    send(0, 3, 1, 0, 0, 1, 1, 0, 0, 4, 0, 0, "R3 upgrade sharer");
    send(0, 3, 3, 0, 0, 1, 1, 0, 0, 3, 0, 0, "R3 upgrade nonsharer");
    send(0, 3, 2, 0, 0, 0, 1, 0, 0, 3, 0, 0, "R3 upgrade invalid line");
    // R4
    send(0, 4, 2, 1, 0, 1, 1, 0, 0, 5, 0, 0, "R4 writeback");
    send(0, 4, 5, 1, 0, 1, 1, 0, 0, 6, 0, 0, "R4 stale writeback");
    // R5
    send(0, 0, 1, 0, 0, 0, 0, 1, 0, 7, 1, 0, "R5 repl dirty");
    send(0, 2, 4, 0, 0, 0, 0, 0, 0, 8, 1, 0, "R5 repl clean");
    send(0, 3, 6, 0, 0, 0, 0, 1, 0, 7, 1, 0, "R5 upgrade overlap repl");
    send(0, 0, 1, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R5 free way no repl");
    send(1, 0, 1, 1, 0, 0, 0, 1, 0, 9, 0, 0, "R5 response not replaced");
    // R6
    send(1, 0, 2, 0, 0, 1, 1, 0, 0, 10, 0, 0, "R6 clean data");
    // R7
    send(1, 1, 1, 0, 3, 1, 1, 0, 3, 12, 0, 0, "R7 last ack");
    send(1, 1, 1, 0, 1, 1, 1, 0, 3, 11, 0, 0, "R7 mid ack");
    send(1, 1, 2, 0, 0, 1, 1, 0, 0, 12, 0, 0, "R7 zero zero");
    send(1, 1, 2, 0, 1, 1, 1, 0, 0, 11, 0, 0, "R7 wrap");
    // R8
    send(2, 0, 0, 0, 0, 0, 1, 0, 0, 13, 0, 0, "R8 mem data");
    send(2, 1, 0, 0, 0, 1, 1, 0, 0, 14, 0, 0, "R8 mem ack");
    send(2, 2, 0, 0, 0, 1, 0, 0, 0, 15, 0, 0, "R8 mem inv");
    // R9
    send(3, 0, 1, 0, 0, 1, 1, 0, 0, 16, 0, 0, "R9 unblock");
    send(3, 1, 1, 0, 0, 1, 1, 0, 0, 17, 0, 0, "R9 excl unblock");
    // R10
    send(0, 7, 1, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R10 req err full set");
    send(1, 2, 1, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R10 rsp err");
    send(2, 3, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R10 mem err");
    send(3, 5, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R10 unblock err");
    @(negedge clk);
    chk(msg_ready && !evt_valid, "R10 ready kept", int'(msg_ready), 1);
    send(3, 1, 4, 0, 0, 1, 1, 0, 0, 17, 0, 0, "R9 after errors");
    while (sb.size() != 0 || evt_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule